// File: doc/BRIEF.md
# Transmit Attempt Sequencer with Collision Test Mode

This block runs the transmission attempts of one frame in a 10 Mb/s carrier-sense MAC. When a frame is launched it opens an attempt and watches the collision line. It finishes in one of two ways. If the attempt ends cleanly, the frame is done. If a collision arrives, it waits a programmable backoff count and opens the next attempt. When the attempt limit is used up, it raises a sticky retry error. It also decides, once per frame, whether the frame check sequence is to be appended.

Three mode bits shape the sequencing:
- A single-shot bit cuts the attempt limit to one.
- A collision-injection bit makes every attempt collide, but only while internal loopback is on. This lets the retry-error path be exercised without a real medium.
- A global FCS-suppress bit turns off the check sequence, and a per-frame flag can override it.

The mode bits are protected. The single-shot, injection and FCS-suppress bits accept writes only while the controller is stopped or suspended. The loopback bit accepts writes only while it is stopped.

Top module: `tx_retry_ctrl`

## Requirements
- R1: With the single-shot bit (mode bit 0) clear, a frame that collides on every attempt gets exactly MAX_ATTEMPTS (16) attempts. The collision on the last attempt sets retry_err_o, and the controller returns to idle without pulsing tx_done_o.
- R2: With the single-shot bit set, exactly one attempt is made. A collision on it sets retry_err_o at once.
- R3: With collision injection (mode bit 1) and loopback (mode bit 3) both set, every attempt collides even when coll_i stays low and xmit_end_i is asserted. The frame ends in retry_err_o after the full attempt count.
- R4: Collision injection alone, with loopback clear, has no effect: an attempt ended by xmit_end_i without coll_i completes with tx_done_o.
- R5: With the FCS-suppress bit (mode bit 2) clear, append_fcs_o is 1 for every frame, whatever the per-frame flag is.
- R6: With the FCS-suppress bit set, append_fcs_o follows the per-frame flag frame_add_fcs_i sampled at frame start: 0 when the flag is clear, 1 when it is set.
- R7: A cfg_wr_i write updates mode bits 0, 1 and 2 only while stop_i or suspend_i is high. Otherwise those bits keep their value.
- R8: A cfg_wr_i write updates mode bit 3 only while stop_i is high. A write made with only suspend_i high leaves it unchanged.
- R9: An attempt ended by xmit_end_i with no collision produces a one-cycle tx_done_o pulse and returns to idle. The attempt count restarts at 1 when the next frame starts, and retry_err_o clears when the next frame starts.
- R10: After a collision, attempt_o stays low for backoff_len_i+1 cycles before the next attempt opens.
- R11: After reset the controller is idle (busy_o=0, attempt_o=0), all mode bits are 0, and retry_err_o, tx_done_o and the attempt count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_i | input | 1 | Controller stopped; opens writes to all mode bits |
| suspend_i | input | 1 | Controller suspended; opens writes to mode bits 0..2 |
| cfg_wr_i | input | 1 | Mode write strobe |
| cfg_wdata_i | input | 4 | Mode data: [0] single-shot, [1] collision injection, [2] FCS suppress, [3] loopback |
| frame_start_i | input | 1 | Launch a frame (taken in idle) |
| frame_add_fcs_i | input | 1 | Per-frame FCS force flag, sampled with frame_start_i |
| backoff_len_i | input | BACKOFF_W | Backoff count loaded after each collision |
| coll_i | input | 1 | Collision seen during the current attempt |
| xmit_end_i | input | 1 | Current attempt finished on the wire |
| attempt_o | output | 1 | An attempt is in progress |
| busy_o | output | 1 | A frame is being handled |
| tx_done_o | output | 1 | One-cycle pulse on successful completion |
| retry_err_o | output | 1 | Sticky retry error, cleared at next frame start |
| append_fcs_o | output | 1 | FCS is to be appended to the current frame |
| attempt_cnt_o | output | CNT_W | Number of the current attempt (1-based) |
| mode_o | output | 4 | Current mode bits, same layout as cfg_wdata_i |

## Verification
The bench builds the block with MAX_ATTEMPTS=16 and BACKOFF_W=8. This puts the full sixteen-attempt collision run, and its exhaustion into a retry error, within a few hundred cycles. Backoff lengths of 0, 3 and 7 cover the shortest gap and longer ones, so the gap length can be checked against each loaded count. Mode writes are tried under every combination of stop and suspend, to exercise the different guards on the loopback bit and on the other three bits.

// File: rtl/tx_retry_ctrl.sv
module tx_retry_ctrl #(
  parameter int MAX_ATTEMPTS = 16,
  parameter int BACKOFF_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stop_i,
  input  logic                 suspend_i,
  input  logic                 cfg_wr_i,
  input  logic [3:0]           cfg_wdata_i,
  input  logic                 frame_start_i,
  input  logic                 frame_add_fcs_i,
  input  logic [BACKOFF_W-1:0] backoff_len_i,
  input  logic                 coll_i,
  input  logic                 xmit_end_i,
  output logic                 attempt_o,
  output logic                 busy_o,
  output logic                 tx_done_o,
  output logic                 retry_err_o,
  output logic                 append_fcs_o,
  output logic [$clog2(MAX_ATTEMPTS+1)-1:0] attempt_cnt_o,
  output logic [3:0]           mode_o
);
  localparam int CNT_W = $clog2(MAX_ATTEMPTS+1);
  localparam logic [CNT_W-1:0] LIMIT_FULL = CNT_W'(MAX_ATTEMPTS);
  localparam logic [CNT_W-1:0] LIMIT_ONE  = CNT_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_TRY, S_WAIT} state_t;

  state_t               state;
  logic [CNT_W-1:0]     tries;
  logic [BACKOFF_W-1:0] wait_cnt;
  logic                 single_shot, inject, fcs_off, lpbk;
  logic                 hit, last_try;
  logic [CNT_W-1:0]     limit;

  assign limit    = single_shot ? LIMIT_ONE : LIMIT_FULL;
  assign hit      = coll_i | (inject & lpbk);
  assign last_try = (tries >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      single_shot <= 1'b0;
      inject      <= 1'b0;
      fcs_off     <= 1'b0;
      lpbk        <= 1'b0;
    end else if (cfg_wr_i) begin
      if (stop_i || suspend_i) begin
        single_shot <= cfg_wdata_i[0];
        inject      <= cfg_wdata_i[1];
        fcs_off     <= cfg_wdata_i[2];
      end
      if (stop_i) lpbk <= cfg_wdata_i[3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      tries        <= '0;
      wait_cnt     <= '0;
      tx_done_o    <= 1'b0;
      retry_err_o  <= 1'b0;
      append_fcs_o <= 1'b0;
    end else begin
      tx_done_o <= 1'b0;
      case (state)
        S_IDLE: if (frame_start_i) begin
          state        <= S_TRY;
          tries        <= CNT_W'(1);
          retry_err_o  <= 1'b0;
          append_fcs_o <= ~fcs_off | frame_add_fcs_i;
        end
        S_TRY: begin
          if (hit) begin
            if (last_try) begin
              state       <= S_IDLE;
              retry_err_o <= 1'b1;
            end else begin
              state    <= S_WAIT;
              wait_cnt <= backoff_len_i;
            end
          end else if (xmit_end_i) begin
            state     <= S_IDLE;
            tx_done_o <= 1'b1;
          end
        end
        S_WAIT: begin
          if (wait_cnt == '0) begin
            state <= S_TRY;
            tries <= tries + CNT_W'(1);
          end else begin
            wait_cnt <= wait_cnt - BACKOFF_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign attempt_o     = (state == S_TRY);
  assign busy_o        = (state != S_IDLE);
  assign attempt_cnt_o = tries;
  assign mode_o        = {lpbk, fcs_off, inject, single_shot};
endmodule

module tx_retry_ctrl_chk #(
  parameter int MAX_ATTEMPTS = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 stop_i,
  input logic                 suspend_i,
  input logic                 attempt_o,
  input logic                 busy_o,
  input logic                 tx_done_o,
  input logic                 retry_err_o,
  input logic [$clog2(MAX_ATTEMPTS+1)-1:0] attempt_cnt_o,
  input logic [3:0]           mode_o
);
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    attempt_cnt_o <= ($clog2(MAX_ATTEMPTS+1))'(MAX_ATTEMPTS));

  p_err_after_try_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_err_o) |-> $past(attempt_o));

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_i || suspend_i) |=> $stable(mode_o[2:0]));

  p_lpbk_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_i |=> $stable(mode_o[3]));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_o |-> (!busy_o && !retry_err_o));

  p_try_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    attempt_o |-> busy_o);
endmodule

bind tx_retry_ctrl tx_retry_ctrl_chk #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .suspend_i(suspend_i),
  .attempt_o(attempt_o), .busy_o(busy_o), .tx_done_o(tx_done_o),
  .retry_err_o(retry_err_o), .attempt_cnt_o(attempt_cnt_o), .mode_o(mode_o)
);

// File: tb/tx_retry_ctrl_test.sv
module tx_retry_ctrl_test;
  localparam int MAXA = 16;
  localparam int BW   = 8;
  localparam int CW   = $clog2(MAXA+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic stop_i = 0, suspend_i = 0, cfg_wr_i = 0;
  logic [3:0] cfg_wdata_i = '0;
  logic frame_start_i = 0, frame_add_fcs_i = 0;
  logic [BW-1:0] backoff_len_i = '0;
  logic coll_i = 0, xmit_end_i = 0;
  logic attempt_o, busy_o, tx_done_o, retry_err_o, append_fcs_o;
  logic [CW-1:0] attempt_cnt_o;
  logic [3:0] mode_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tx_retry_ctrl #(.MAX_ATTEMPTS(MAXA), .BACKOFF_W(BW)) uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_mode(input bit st, input bit sp, input logic [3:0] d);
    @(negedge clk);
    stop_i = st; suspend_i = sp; cfg_wr_i = 1; cfg_wdata_i = d;
    @(negedge clk);
    cfg_wr_i = 0; stop_i = 0; suspend_i = 0;
  endtask

  // Runs one frame; collides on the first ncoll attempts (coll_i), ends the rest with xmit_end_i.
  task automatic run_frame(input bit add, input int ncoll, input int bo,
                           output int tries, output bit done, output bit err,
                           output bit fcs, output int gap_bad, output int first_cnt);
    int gap = 0;
    @(negedge clk);
    frame_start_i = 1; frame_add_fcs_i = add; backoff_len_i = BW'(bo);
    @(negedge clk);
    frame_start_i = 0;
    fcs = append_fcs_o; first_cnt = int'(attempt_cnt_o);
    tries = 0; done = 0; err = 0; gap_bad = 0;
    for (int c = 0; c < 5000 && !done && !err; c++) begin
      if (attempt_o) begin
        tries++;
        if (tries > 1 && gap != bo + 1) gap_bad++;
        gap = 0;
        if (tries <= ncoll) coll_i = 1; else xmit_end_i = 1;
        @(negedge clk);
        coll_i = 0; xmit_end_i = 0;
        done = tx_done_o; err = retry_err_o;
      end else begin
        gap++;
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset;
    chk("R11 busy", busy_o, 0);
    chk("R11 attempt", attempt_o, 0);
    chk("R11 mode", mode_o, 0);
    chk("R11 retry_err", retry_err_o, 0);
    chk("R11 done", tx_done_o, 0);
    chk("R11 count", attempt_cnt_o, 0);
  endtask

  task automatic t_write_guards;
    write_mode(0, 0, 4'hF);
    chk("R7 write ignored when running", mode_o[2:0], 0);
    chk("R8 loopback ignored when running", mode_o[3], 0);
    write_mode(0, 1, 4'hF);
    chk("R7 write under suspend", mode_o[2:0], 7);
    chk("R8 loopback ignored under suspend", mode_o[3], 0);
    write_mode(1, 0, 4'h8);
    chk("R8 loopback under stop", mode_o, 4'h8);
    write_mode(0, 0, 4'h7);
    chk("R7 clear ignored when running", mode_o, 4'h8);
    write_mode(1, 0, 4'h0);
    chk("R7 clear under stop", mode_o, 0);
  endtask

  task automatic t_success;
    int n, g, fc; bit d, e, f;
    run_frame(0, 0, 0, n, d, e, f, g, fc);
    chk("R9 done pulse", d, 1);
    chk("R9 single attempt", n, 1);
    chk("R5 fcs appended", f, 1);
    @(negedge clk);
    chk("R9 done is one cycle", tx_done_o, 0);
    chk("R9 idle after done", busy_o, 0);
    run_frame(1, 3, 3, n, d, e, f, g, fc);
    chk("R9 count restarts at 1", fc, 1);
    chk("R9 done after collisions", d, 1);
    chk("R9 attempts", n, 4);
    chk("R10 backoff gap len 3", g, 0);
    chk("R5 fcs with flag", f, 1);
  endtask

  task automatic t_exhaust;
    int n, g, fc; bit d, e, f;
    run_frame(0, 100, 0, n, d, e, f, g, fc);
    chk("R1 attempts", n, MAXA);
    chk("R1 retry err", e, 1);
    chk("R1 no done", d, 0);
    chk("R10 backoff gap len 0", g, 0);
    chk("R1 idle", busy_o, 0);
    run_frame(0, 0, 0, n, d, e, f, g, fc);
    chk("R9 error clears at frame start", retry_err_o, 0);
  endtask

  task automatic t_single_shot;
    int n, g, fc; bit d, e, f;
    write_mode(0, 1, 4'h1);
    run_frame(0, 100, 7, n, d, e, f, g, fc);
    chk("R2 one attempt", n, 1);
    chk("R2 retry err", e, 1);
    chk("R2 idle", busy_o, 0);
    write_mode(1, 0, 4'h0);
  endtask

  task automatic t_inject;
    int n, g, fc; bit d, e, f;
    write_mode(0, 1, 4'h2);
    run_frame(0, 0, 0, n, d, e, f, g, fc);
    chk("R4 injection without loopback", d, 1);
    chk("R4 no error", e, 0);
    write_mode(1, 0, 4'hA);
    run_frame(0, 0, 7, n, d, e, f, g, fc);
    chk("R3 forced attempts", n, MAXA);
    chk("R3 forced retry err", e, 1);
    chk("R3 no done", d, 0);
    chk("R10 backoff gap len 7", g, 0);
    write_mode(1, 0, 4'h0);
  endtask

  task automatic t_fcs;
    int n, g, fc; bit d, e, f;
    write_mode(1, 0, 4'h4);
    run_frame(0, 0, 0, n, d, e, f, g, fc);
    chk("R6 suppressed", f, 0);
    run_frame(1, 0, 0, n, d, e, f, g, fc);
    chk("R6 per-frame override", f, 1);
    write_mode(0, 1, 4'h0);
    run_frame(0, 0, 0, n, d, e, f, g, fc);
    chk("R5 fcs appended again", f, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_guards();
    t_success();
    t_exhaust();
    t_single_shot();
    t_inject();
    t_fcs();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule